// File: doc/BRIEF.md
# Fine-grained system-register write trap checker

This block decides whether one attempted write to a system register has to be diverted to the hypervisor. The caller supplies the 64-bit trap-control word that the hypervisor programmed, and the 6-bit index of the control bit that governs the target register. It also supplies the exception level the write comes from (EL0 or EL1) and the kind of write instruction: a single 64-bit move, a paired 128-bit move, or a legacy 32-bit coprocessor move. A set of condition flags completes the inputs: hypervisor level implemented and enabled, monitor level present, the monitor's fine-grained-trap enable, the host-mode pair {E2H,TGE}, a per-bit feature-present mask, and a flag saying that the write already raises a higher-priority exception.

The decision is computed combinationally and registered once. One cycle after a request strobe the block raises a valid strobe, together with a trap flag and a 6-bit exception class. Decoding the register name into the bit index and delivering the exception are done by neighbouring logic.

Top module: `fgt_wr_trap_chk`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid_o`, `trap_o` and `ec_o` are all 0.
- R2: `rsp_valid_o` is high exactly in the cycle after a cycle in which `req_i` was high, and low otherwise.
- R3: Control bits 63 down to 50 are active-low (0 requests a trap, 1 disables it). Control bits 49 down to 0 are active-high (1 requests a trap).
- R4: The reserved positions 2, 9, 10, 14, 15, 18, 21, 25, 26, 28, 40, 42, 46 and 51 never produce a trap, whatever their control value.
- R5: A bit whose feature-present input `feat_mask_i[idx]` is 0 never produces a trap.
- R6: A trap requires `hyp_en_i`=1 and either `mon_present_i`=0 or `mon_fgt_en_i`=1.
- R7: When `hi_pri_exc_i`=1 no trap is reported.
- R8: The class of a trap depends on the write kind (`wr_kind_i`: 0 single 64-bit, 1 paired 128-bit, 2 legacy 32-bit coprocessor). Single gives 0x18, paired gives 0x14, legacy gives 0x03.
- R9: A paired write traps only through bits 56, 37, 36 or 27, and only from EL1.
- R10: A legacy write traps only through bit 35, only from EL0, only with `el1_aa64_i`=1, and only when {E2H,TGE} is not {1,1}. Kind code 3 never traps.
- R11: Bits 59, 55, 35 and 31 trap single writes from EL0 and from EL1, but not while {E2H,TGE}={1,1}. Every other bit traps single writes only from EL1 (`from_el1_i`=1), regardless of host mode.
- R12: When `trap_o` is 0, `ec_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Request strobe: judge the inputs of this cycle |
| ctrl_word_i | input | 64 | Trap-control word |
| bit_idx_i | input | 6 | Index of the control bit covering the target register |
| from_el1_i | input | 1 | 1: write comes from EL1, 0: from EL0 |
| wr_kind_i | input | 2 | 0 single, 1 paired, 2 legacy coprocessor, 3 none |
| el1_aa64_i | input | 1 | EL1 runs in 64-bit state |
| hyp_en_i | input | 1 | Hypervisor level implemented and enabled in this security state |
| mon_present_i | input | 1 | Monitor level implemented |
| mon_fgt_en_i | input | 1 | Monitor's fine-grained-trap enable |
| host_e2h_i | input | 1 | Effective host-mode E2H |
| host_tge_i | input | 1 | Effective host-mode TGE |
| feat_mask_i | input | 64 | Per-bit optional-feature present |
| hi_pri_exc_i | input | 1 | Write already raises a higher-priority exception |
| rsp_valid_o | output | 1 | Result valid, one cycle after `req_i` |
| trap_o | output | 1 | Write is trapped to the hypervisor |
| ec_o | output | 6 | Exception class of the trap, 0 when no trap |

## Verification
The hardest case to reach is the legacy coprocessor path. It needs five conditions at once: bit 35 selected and armed, a request from EL0, EL1 in 64-bit state, host mode not {1,1}, and the legacy kind. A random mix of inputs almost never lines these up. The bench starts from that exact combination, confirms class 0x03, and then breaks one condition at a time, showing that each one alone removes the trap. The paired-write and EL0-visible bits get the same treatment, and each active-low bit is checked against an active-high neighbour across the boundary at bits 50 and 49.

// File: rtl/fgt_wr_pkg.sv
// Shared constants and types for the fine-grained write trap checker.
// Assumes a 64-bit control word; all masks below are indexed by control bit.
package fgt_wr_pkg;
    localparam int CTRL_W       = 64;
    localparam int ACT_LOW_FROM = 50;   // bits at or above this trap on 0
    localparam int LEGACY_BIT   = 35;   // only bit with a legacy write path

    typedef enum logic [1:0] {
        WK_SINGLE = 2'd0,
        WK_PAIR   = 2'd1,
        WK_LEGACY = 2'd2,
        WK_NONE   = 2'd3
    } wr_kind_e;

    localparam logic [63:0] RSVD_MASK = 64'h0008_4500_1624_C604;
    localparam logic [63:0] PAIR_MASK = 64'h0100_0030_0800_0000;
    localparam logic [63:0] EL0_MASK  = 64'h0880_0008_8000_0000;

    localparam logic [5:0] EC_SINGLE = 6'h18;
    localparam logic [5:0] EC_PAIR   = 6'h14;
    localparam logic [5:0] EC_LEGACY = 6'h03;
endpackage

// File: rtl/fgt_bit_arm.sv
// Normalises the control word to one polarity (1 = trap requested), strips
// reserved and feature-absent positions, and picks the indexed bit together
// with its class flags. Assumes CTRL_W <= 64 (the masks are 64 bits wide).
module fgt_bit_arm
    import fgt_wr_pkg::*;
#(
    parameter int W        = CTRL_W,
    parameter int IDX_W    = $clog2(W),
    parameter int LOW_FROM = ACT_LOW_FROM
) (
    input  logic [W-1:0]     ctrl_i,
    input  logic [W-1:0]     feat_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             bit_on_o,
    output logic             el0_bit_o,
    output logic             pair_bit_o,
    output logic             legacy_bit_o
);
    localparam logic [W-1:0] RSVD = RSVD_MASK[W-1:0];
    localparam logic [W-1:0] PAIR = PAIR_MASK[W-1:0];
    localparam logic [W-1:0] EL0V = EL0_MASK[W-1:0];

    logic [W-1:0] armed;
    logic [W-1:0] live;

    // Per-bit polarity correction, chosen by position.
    for (genvar g = 0; g < W; g++) begin : g_pol
        if (g >= LOW_FROM) begin : g_low
            assign armed[g] = ~ctrl_i[g];
        end else begin : g_high
            assign armed[g] = ctrl_i[g];
        end
    end

    // Remove reserved and absent-feature positions, then select.
    always_comb begin
        live         = armed & feat_i & ~RSVD;
        bit_on_o     = live[idx_i];
        el0_bit_o    = EL0V[idx_i];
        pair_bit_o   = PAIR[idx_i];
        legacy_bit_o = (idx_i == IDX_W'(LEGACY_BIT));
    end
endmodule

// File: rtl/fgt_route_qual.sv
// Applies the global enable, priority, exception-level, host-mode and
// write-kind rules to an armed bit and selects the exception class.
// Assumes its inputs come straight from fgt_bit_arm in the same cycle.
module fgt_route_qual
    import fgt_wr_pkg::*;
(
    input  logic       bit_on_i,
    input  logic       el0_bit_i,
    input  logic       pair_bit_i,
    input  logic       legacy_bit_i,
    input  wr_kind_e   kind_i,
    input  logic       from_el1_i,
    input  logic       el1_aa64_i,
    input  logic       hyp_en_i,
    input  logic       mon_present_i,
    input  logic       mon_fgt_en_i,
    input  logic       host_e2h_i,
    input  logic       host_tge_i,
    input  logic       hi_pri_i,
    output logic       trap_o,
    output logic [5:0] ec_o
);
    logic       gate_ok;
    logic       host_both;
    logic       route_ok;
    logic [5:0] ec_sel;

    // Decide trap and class for the current write.
    always_comb begin
        gate_ok   = hyp_en_i & (~mon_present_i | mon_fgt_en_i) & ~hi_pri_i;
        host_both = host_e2h_i & host_tge_i;
        route_ok  = 1'b0;
        ec_sel    = 6'h00;
        case (kind_i)
            WK_SINGLE: begin
                route_ok = el0_bit_i ? ~host_both : from_el1_i;
                ec_sel   = EC_SINGLE;
            end
            WK_PAIR: begin
                route_ok = pair_bit_i & from_el1_i;
                ec_sel   = EC_PAIR;
            end
            WK_LEGACY: begin
                route_ok = legacy_bit_i & ~from_el1_i & el1_aa64_i & ~host_both;
                ec_sel   = EC_LEGACY;
            end
            default: begin
                route_ok = 1'b0;
                ec_sel   = 6'h00;
            end
        endcase
        trap_o = gate_ok & bit_on_i & route_ok;
        ec_o   = trap_o ? ec_sel : 6'h00;
    end
endmodule

// File: rtl/fgt_wr_trap_chk.sv
// Top of the write trap checker: combinational judgement of one write,
// registered once; rsp_valid_o follows req_i by one cycle.
// Assumes a synchronous active-low reset and a 64-bit control word.
module fgt_wr_trap_chk
    import fgt_wr_pkg::*;
#(
    parameter int W     = CTRL_W,
    parameter int IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [W-1:0]     ctrl_word_i,
    input  logic [IDX_W-1:0] bit_idx_i,
    input  logic             from_el1_i,
    input  logic [1:0]       wr_kind_i,
    input  logic             el1_aa64_i,
    input  logic             hyp_en_i,
    input  logic             mon_present_i,
    input  logic             mon_fgt_en_i,
    input  logic             host_e2h_i,
    input  logic             host_tge_i,
    input  logic [W-1:0]     feat_mask_i,
    input  logic             hi_pri_exc_i,
    output logic             rsp_valid_o,
    output logic             trap_o,
    output logic [5:0]       ec_o
);
    logic       bit_on, el0_bit, pair_bit, legacy_bit;
    logic       trap_c;
    logic [5:0] ec_c;

    fgt_bit_arm #(.W(W), .IDX_W(IDX_W), .LOW_FROM(ACT_LOW_FROM)) u_arm (
        .ctrl_i       (ctrl_word_i),
        .feat_i       (feat_mask_i),
        .idx_i        (bit_idx_i),
        .bit_on_o     (bit_on),
        .el0_bit_o    (el0_bit),
        .pair_bit_o   (pair_bit),
        .legacy_bit_o (legacy_bit)
    );

    fgt_route_qual u_qual (
        .bit_on_i      (bit_on),
        .el0_bit_i     (el0_bit),
        .pair_bit_i    (pair_bit),
        .legacy_bit_i  (legacy_bit),
        .kind_i        (wr_kind_e'(wr_kind_i)),
        .from_el1_i    (from_el1_i),
        .el1_aa64_i    (el1_aa64_i),
        .hyp_en_i      (hyp_en_i),
        .mon_present_i (mon_present_i),
        .mon_fgt_en_i  (mon_fgt_en_i),
        .host_e2h_i    (host_e2h_i),
        .host_tge_i    (host_tge_i),
        .hi_pri_i      (hi_pri_exc_i),
        .trap_o        (trap_c),
        .ec_o          (ec_c)
    );

    // Register the decision; outputs are zero when no request was made.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            trap_o      <= 1'b0;
            ec_o        <= 6'h00;
        end else begin
            rsp_valid_o <= req_i;
            trap_o      <= req_i & trap_c;
            ec_o        <= req_i ? ec_c : 6'h00;
        end
    end

    // Response strobe follows the request by one cycle.
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> rsp_valid_o);
    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !rsp_valid_o);
    // Reserved positions never trap.
    assert_rsvd_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && RSVD_MASK[bit_idx_i]) |=> !trap_o);
    // Absent feature never traps.
    assert_feat_absent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !feat_mask_i[bit_idx_i]) |=> !trap_o);
    // Global enable conditions.
    assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && (!hyp_en_i || (mon_present_i && !mon_fgt_en_i))) |=> !trap_o);
    // Higher-priority exception suppresses the trap.
    assert_hipri_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && hi_pri_exc_i) |=> !trap_o);
    // Class matches the registered write kind.
    assert_ec_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> ((ec_o == EC_SINGLE && $past(wr_kind_i) == 2'd0) ||
                    (ec_o == EC_PAIR   && $past(wr_kind_i) == 2'd1) ||
                    (ec_o == EC_LEGACY && $past(wr_kind_i) == 2'd2)));
    // Paired writes only through their own bits.
    assert_pair_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && wr_kind_i == 2'd1 && !PAIR_MASK[bit_idx_i]) |=> !trap_o);
    // Legacy writes never from EL1.
    assert_legacy_el0_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && wr_kind_i == 2'd2 && from_el1_i) |=> !trap_o);
    // Non-EL0-visible bits never trap from EL0.
    assert_el0_scope_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !from_el1_i && !EL0_MASK[bit_idx_i] && wr_kind_i == 2'd0) |=> !trap_o);
    // No trap means a zero class.
    assert_ec_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_o |-> (ec_o == 6'h00));
endmodule

// File: tb/fgt_wr_trap_chk_tb.sv
module fgt_wr_trap_chk_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [63:0] ctrl_word_i = '0;
    logic [5:0]  bit_idx_i = '0;
    logic        from_el1_i = 1'b1;
    logic [1:0]  wr_kind_i = 2'd0;
    logic        el1_aa64_i = 1'b1;
    logic        hyp_en_i = 1'b1;
    logic        mon_present_i = 1'b1;
    logic        mon_fgt_en_i = 1'b1;
    logic        host_e2h_i = 1'b0;
    logic        host_tge_i = 1'b0;
    logic [63:0] feat_mask_i = '1;
    logic        hi_pri_exc_i = 1'b0;
    logic        rsp_valid_o, trap_o;
    logic [5:0]  ec_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    fgt_wr_trap_chk u_dut (.*);

    task automatic check(input logic exp_trap, input logic [5:0] exp_ec, input string tag);
        n_chk++;
        if (rsp_valid_o !== 1'b1 || trap_o !== exp_trap || ec_o !== exp_ec) begin
            n_fail++;
            $display("FAIL %s: valid=%0b trap=%0b ec=0x%02h expected valid=1 trap=%0b ec=0x%02h",
                     tag, rsp_valid_o, trap_o, ec_o, exp_trap, exp_ec);
        end
    endtask

    // Restore the trap-enabling environment.
    task automatic env_default();
        from_el1_i = 1'b1; wr_kind_i = 2'd0; el1_aa64_i = 1'b1;
        hyp_en_i = 1'b1; mon_present_i = 1'b1; mon_fgt_en_i = 1'b1;
        host_e2h_i = 1'b0; host_tge_i = 1'b0; feat_mask_i = '1; hi_pri_exc_i = 1'b0;
    endtask

    // One request: control bit idx set to v (others the inverse), result checked.
    task automatic judge(input int idx, input logic v, input logic exp_trap,
                         input logic [5:0] exp_ec, input string tag);
        @(negedge clk);
        bit_idx_i   = 6'(idx);
        ctrl_word_i = v ? (64'h1 << idx) : ~(64'h1 << idx);
        req_i       = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        check(exp_trap, exp_ec, tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        n_chk++;
        if (rsp_valid_o !== 1'b0 || trap_o !== 1'b0 || ec_o !== 6'h00) begin
            n_fail++;
            $display("FAIL R1: valid=%0b trap=%0b ec=0x%02h expected all 0", rsp_valid_o, trap_o, ec_o);
        end
    endtask

    task automatic t_valid();
        env_default();
        judge(0, 1'b1, 1'b1, 6'h18, "R2 strobe");
        @(negedge clk);
        n_chk++;
        if (rsp_valid_o !== 1'b0 || trap_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R2: valid=%0b trap=%0b expected 0 0 after idle", rsp_valid_o, trap_o);
        end
    endtask

    task automatic t_polarity();
        env_default();
        judge(63, 1'b0, 1'b1, 6'h18, "R3 bit63=0");
        judge(63, 1'b1, 1'b0, 6'h00, "R3 bit63=1");
        judge(50, 1'b0, 1'b1, 6'h18, "R3 bit50=0");
        judge(49, 1'b1, 1'b1, 6'h18, "R3 bit49=1");
        judge(49, 1'b0, 1'b0, 6'h00, "R3 bit49=0");
        judge(0,  1'b1, 1'b1, 6'h18, "R3 bit0=1");
    endtask

    task automatic t_reserved();
        env_default();
        judge(51, 1'b0, 1'b0, 6'h00, "R4 R12 bit51=0");
        judge(51, 1'b1, 1'b0, 6'h00, "R4 bit51=1");
        judge(2,  1'b1, 1'b0, 6'h00, "R4 bit2=1");
        judge(26, 1'b1, 1'b0, 6'h00, "R4 bit26=1");
        judge(46, 1'b1, 1'b0, 6'h00, "R4 bit46=1");
    endtask

    task automatic t_feature();
        env_default();
        feat_mask_i = ~(64'h1 << 49);
        judge(49, 1'b1, 1'b0, 6'h00, "R5 bit49 absent");
        feat_mask_i = ~(64'h1 << 60);
        judge(60, 1'b0, 1'b0, 6'h00, "R5 bit60 absent");
        judge(49, 1'b1, 1'b1, 6'h18, "R5 other bit present");
    endtask

    task automatic t_gate();
        env_default();
        hyp_en_i = 1'b0;
        judge(17, 1'b1, 1'b0, 6'h00, "R6 hyp off");
        env_default();
        mon_fgt_en_i = 1'b0;
        judge(17, 1'b1, 1'b0, 6'h00, "R6 monitor disables");
        mon_present_i = 1'b0;
        judge(17, 1'b1, 1'b1, 6'h18, "R6 no monitor");
    endtask

    task automatic t_hipri();
        env_default();
        hi_pri_exc_i = 1'b1;
        judge(24, 1'b1, 1'b0, 6'h00, "R7 suppressed");
        hi_pri_exc_i = 1'b0;
        judge(24, 1'b1, 1'b1, 6'h18, "R7 released");
    endtask

    task automatic t_pair();
        env_default();
        wr_kind_i = 2'd1;
        judge(37, 1'b1, 1'b1, 6'h14, "R8 R9 pair bit37");
        judge(56, 1'b0, 1'b1, 6'h14, "R9 pair bit56");
        judge(27, 1'b1, 1'b1, 6'h14, "R9 pair bit27");
        judge(38, 1'b1, 1'b0, 6'h00, "R9 pair bit38");
        from_el1_i = 1'b0;
        judge(36, 1'b1, 1'b0, 6'h00, "R9 pair from EL0");
    endtask

    task automatic t_legacy();
        env_default();
        wr_kind_i = 2'd2; from_el1_i = 1'b0;
        judge(35, 1'b1, 1'b1, 6'h03, "R8 R10 legacy hit");
        from_el1_i = 1'b1;
        judge(35, 1'b1, 1'b0, 6'h00, "R10 legacy from EL1");
        from_el1_i = 1'b0; el1_aa64_i = 1'b0;
        judge(35, 1'b1, 1'b0, 6'h00, "R10 EL1 32-bit");
        el1_aa64_i = 1'b1;
        judge(34, 1'b1, 1'b0, 6'h00, "R10 legacy bit34");
        host_e2h_i = 1'b1; host_tge_i = 1'b1;
        judge(35, 1'b1, 1'b0, 6'h00, "R10 host mode");
        env_default();
        wr_kind_i = 2'd3;
        judge(35, 1'b1, 1'b0, 6'h00, "R10 kind 3");
    endtask

    task automatic t_el0();
        env_default();
        from_el1_i = 1'b0;
        judge(59, 1'b0, 1'b1, 6'h18, "R11 bit59 EL0");
        judge(31, 1'b1, 1'b1, 6'h18, "R11 bit31 EL0");
        judge(33, 1'b1, 1'b0, 6'h00, "R11 bit33 EL0");
        from_el1_i = 1'b1; host_e2h_i = 1'b1; host_tge_i = 1'b1;
        judge(31, 1'b1, 1'b0, 6'h00, "R11 bit31 host11");
        judge(33, 1'b1, 1'b1, 6'h18, "R11 bit33 host11");
        host_tge_i = 1'b0;
        judge(55, 1'b0, 1'b1, 6'h18, "R11 bit55 host10");
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_valid();
        t_polarity();
        t_reserved();
        t_feature();
        t_gate();
        t_hipri();
        t_pair();
        t_legacy();
        t_el0();
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule